// File: doc/BRIEF.md
# Peripheral DMA Request Port

This block is the peripheral half of a fly-by DMA handshake. It sits inside a device that keeps outbound data in a word buffer, modelled here as a small FIFO. A producer loads words into the buffer and then posts a packet by giving its word count. While posted words are waiting, the port raises a request to an external DMA controller. The controller answers with an acknowledge and a read strobe. For each completed strobe the port presents one buffer word on a 16-bit data bus, counts it, and moves on to the next word.

Two release policies are available. In single-word mode the request drops after every word and comes back only after the acknowledge has gone away. In burst mode the request stays up until the last posted word has moved. In burst mode the buffer can run dry before the count is used up. The port then withdraws the request at once and raises an underrun flag. Data leaves through an output word plus an output enable. The enable tells the pad ring to drive the shared bus and to release it to high impedance at all other times.

Top module: `dma_slave_port`

## Requirements
- R1: After reset `dma_req`, `underrun` and `bus_oe` are all 0.
- R2: `dma_req` goes to 1 only while all of these hold: posted words remain, the buffer holds data, `dma_ack` is 0 and `underrun` is 0.
- R3: `bus_oe` is 1 exactly while `dma_ack` and `rd_act` are both 1. During that time `bus_data` carries the oldest unsent buffer word.
- R4: A word counts as transferred when `rd_act` falls after having been high together with `dma_ack`. The next strobe then shows the following word.
- R5: In single-word mode (`burst_mode` = 0), `dma_req` is 0 in the cycle after each transfer. It stays 0 until `dma_ack` has returned to 0, and it rises again only if posted words remain.
- R6: In burst mode (`burst_mode` = 1), `dma_req` stays 1 across transfers and drops in the cycle after the final posted word.
- R7: A read strobe while `dma_ack` is 0 does not enable the bus and does not consume a word.
- R8: In burst mode, if a transfer empties the buffer while posted words remain, `dma_req` drops in the next cycle and `underrun` becomes 1. The next `pkt_post` clears `underrun`, discards the stale count and loads the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 0 = release after each word, 1 = release after the last word |
| fill_en | input | 1 | Write one word into the buffer |
| fill_data | input | 16 | Word to write |
| pkt_post | input | 1 | Make `pkt_words` more words available for transfer |
| pkt_words | input | 5 | Word count of the posted packet |
| dma_ack | input | 1 | DMA acknowledge from the controller, active high |
| rd_act | input | 1 | Read strobe from the controller, active high |
| dma_req | output | 1 | DMA request to the controller |
| bus_data | output | 16 | Word for the data bus |
| bus_oe | output | 1 | Drive enable for the data bus pads |
| underrun | output | 1 | Buffer ran dry during a burst |

## Verification
The bench runs three single-word transfers. It keeps the acknowledge high after each word to confirm that the request does not come back early, which a design that re-armed on the pop itself would fail. A four-word burst confirms that the request survives the middle words and drops only after the last; a design that reused the single-word release would lose it after word one. A bare read strobe without acknowledge is followed by a real transfer that must still return the same word, which catches a pointer that advances on any strobe. Finally, a burst posted for three words against a buffer holding two must end in an underrun, and a fresh post must recover from it. A design that kept requesting there would let the controller read a stale word.

// File: rtl/dma_slave_pkg.sv
package dma_slave_pkg;
  typedef enum logic {
    REL_PER_WORD  = 1'b0,
    REL_PER_BLOCK = 1'b1
  } release_mode_e;
endpackage

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          do_push, do_pop;

  assign do_push = push && (count_q != CW'(DEPTH));
  assign do_pop  = pop && (count_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
    if (do_pop)  rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/dma_strobe_track.sv
module dma_strobe_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_ack,
  input  logic rd_act,
  output logic drive,
  output logic done
);
  logic armed_q, armed_d;

  assign drive   = dma_ack && rd_act;
  assign armed_d = drive;
  assign done    = armed_q && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_slave_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_mode,
  input  logic          pkt_post,
  input  logic [CW-1:0] pkt_words,
  input  logic          dma_ack,
  input  logic          pop,
  input  logic          push,
  input  logic [CW-1:0] fifo_count,
  output logic          dma_req,
  output logic          underrun
);
  release_mode_e mode;
  logic [CW-1:0] remain_q, remain_d, base, rem_after;
  logic          req_q, req_d, urun_q, urun_d, dry_after;

  assign mode      = release_mode_e'(burst_mode);
  assign rem_after = remain_q - (pop ? CW'(1) : CW'(0));
  assign dry_after = pop && (fifo_count == CW'(1)) && !push;

  always_comb begin
    base     = urun_q ? '0 : remain_q;
    remain_d = base - (pop ? CW'(1) : CW'(0)) + (pkt_post ? pkt_words : CW'(0));

    urun_d = urun_q;
    if (pkt_post)
      urun_d = 1'b0;
    else if (pop && mode == REL_PER_BLOCK && rem_after != '0 && dry_after)
      urun_d = 1'b1;

    req_d = req_q;
    if (pop) begin
      if (mode == REL_PER_WORD) req_d = 1'b0;
      else                      req_d = (rem_after != '0) && !dry_after;
    end else if (!req_q && remain_q != '0 && fifo_count != '0 && !dma_ack && !urun_q) begin
      req_d = 1'b1;
    end else if (req_q && fifo_count == '0) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      req_q    <= 1'b0;
      urun_q   <= 1'b0;
    end else begin
      remain_q <= remain_d;
      req_q    <= req_d;
      urun_q   <= urun_d;
    end
  end

  assign dma_req  = req_q;
  assign underrun = urun_q;
endmodule

// File: rtl/dma_slave_port.sv
module dma_slave_port #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_mode,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              pkt_post,
  input  logic [CW-1:0]     pkt_words,
  input  logic              dma_ack,
  input  logic              rd_act,
  output logic              dma_req,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              underrun
);
  logic          drive_w, done_w, pop_w;
  logic [CW-1:0] count_w;

  dma_strobe_track u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .dma_ack (dma_ack),
    .rd_act  (rd_act),
    .drive   (drive_w),
    .done    (done_w)
  );

  assign pop_w = done_w && (count_w != '0);

  dma_word_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fill_en),
    .push_data (fill_data),
    .pop       (pop_w),
    .head      (bus_data),
    .count     (count_w)
  );

  dma_req_ctrl #(.DEPTH(DEPTH)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_mode (burst_mode),
    .pkt_post   (pkt_post),
    .pkt_words  (pkt_words),
    .dma_ack    (dma_ack),
    .pop        (pop_w),
    .push       (fill_en),
    .fifo_count (count_w),
    .dma_req    (dma_req),
    .underrun   (underrun)
  );

  assign bus_oe = drive_w;
endmodule

// File: rtl/dma_slave_port_chk.sv
module dma_slave_port_chk (
  input logic clk,
  input logic rst_n,
  input logic burst_mode,
  input logic dma_ack,
  input logic rd_act,
  input logic bus_oe,
  input logic dma_req,
  input logic underrun,
  input logic pop
);
  // R5
  single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !burst_mode |=> !dma_req);
  // R2
  no_rearm_under_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req && dma_ack |=> !dma_req);
  // R8
  underrun_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !dma_req && $past(burst_mode));
  // R7
  oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_ack |-> !bus_oe);
  // R4
  pop_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> $past(rd_act) && !rd_act);
endmodule

bind dma_slave_port dma_slave_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .burst_mode (burst_mode),
  .dma_ack    (dma_ack),
  .rd_act     (rd_act),
  .bus_oe     (bus_oe),
  .dma_req    (dma_req),
  .underrun   (underrun),
  .pop        (pop_w)
);

// File: tb/dma_slave_port_test.sv
module dma_slave_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_mode = 1'b0;
  logic        fill_en = 1'b0;
  logic [15:0] fill_data = '0;
  logic        pkt_post = 1'b0;
  logic [4:0]  pkt_words = '0;
  logic        dma_ack = 1'b0;
  logic        rd_act = 1'b0;
  logic        dma_req, bus_oe, underrun;
  logic [15:0] bus_data;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dma_slave_port uut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .fill_en(fill_en),
    .fill_data(fill_data), .pkt_post(pkt_post), .pkt_words(pkt_words),
    .dma_ack(dma_ack), .rd_act(rd_act), .dma_req(dma_req), .bus_data(bus_data),
    .bus_oe(bus_oe), .underrun(underrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int n, input logic [15:0] base, input int post_n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fill_en = 1'b1; fill_data = base + 16'(i);
    end
    @(negedge clk); fill_en = 1'b0; pkt_post = 1'b1; pkt_words = 5'(post_n);
    @(negedge clk); pkt_post = 1'b0;
  endtask

  task automatic wait_req(input string tag);
    int t = 0;
    while (!dma_req && t < 20) begin @(negedge clk); t++; end
    check(dma_req == 1'b1, tag, dma_req, 1);
  endtask

  // one read strobe under dma_ack; leaves the bench one negedge after rd falls
  task automatic strobe(input logic [15:0] exp, input string tag);
    @(negedge clk); rd_act = 1'b1;
    @(negedge clk);
    check(bus_oe == 1'b1, {tag, " R3 oe"}, bus_oe, 1);
    check(bus_data == exp, {tag, " R3/R4 data"}, bus_data, exp);
    rd_act = 1'b0;
    @(negedge clk);
    check(bus_oe == 1'b0, {tag, " R3 release"}, bus_oe, 0);
  endtask

  task automatic t_reset;
    check(dma_req == 1'b0, "R1 req", dma_req, 0);
    check(underrun == 1'b0, "R1 underrun", underrun, 0);
    check(bus_oe == 1'b0, "R1 oe", bus_oe, 0);
    repeat (3) @(negedge clk);
    check(dma_req == 1'b0, "R2 no data no req", dma_req, 0);
  endtask

  task automatic t_single;
    burst_mode = 1'b0;
    load(3, 16'hA000, 3);
    for (int i = 0; i < 3; i++) begin
      wait_req("R2 single req");
      dma_ack = 1'b1;
      strobe(16'hA000 + 16'(i), "R5 single");
      check(dma_req == 1'b0, "R5 drop after word", dma_req, 0);
      repeat (3) @(negedge clk);
      check(dma_req == 1'b0, "R5 held low under ack", dma_req, 0);
      dma_ack = 1'b0;
      repeat (2) @(negedge clk);
      check(dma_req == (i < 2), "R5 reassert when words remain", dma_req, (i < 2));
    end
  endtask

  task automatic t_burst;
    burst_mode = 1'b1;
    load(4, 16'hB000, 4);
    wait_req("R2 burst req");
    dma_ack = 1'b1;
    for (int i = 0; i < 4; i++) begin
      strobe(16'hB000 + 16'(i), "R6 burst");
      check(dma_req == (i < 3), "R6 burst hold/release", dma_req, (i < 3));
    end
    dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    check(dma_req == 1'b0, "R6 stays low when done", dma_req, 0);
  endtask

  task automatic t_stray_rd;
    burst_mode = 1'b0;
    load(1, 16'hC000, 1);
    wait_req("R2 stray req");
    @(negedge clk); rd_act = 1'b1;
    @(negedge clk);
    check(bus_oe == 1'b0, "R7 no drive without ack", bus_oe, 0);
    rd_act = 1'b0;
    repeat (2) @(negedge clk);
    check(dma_req == 1'b1, "R7 req kept", dma_req, 1);
    dma_ack = 1'b1;
    strobe(16'hC000, "R7 same word");
    dma_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_underrun;
    burst_mode = 1'b1;
    load(2, 16'hD000, 3);
    wait_req("R2 underrun req");
    dma_ack = 1'b1;
    strobe(16'hD000, "R8 w0");
    check(dma_req == 1'b1, "R8 still bursting", dma_req, 1);
    strobe(16'hD001, "R8 w1");
    check(dma_req == 1'b0, "R8 req dropped", dma_req, 0);
    check(underrun == 1'b1, "R8 flag set", underrun, 1);
    dma_ack = 1'b0;
    repeat (3) @(negedge clk);
    check(dma_req == 1'b0, "R8 no req while underrun", dma_req, 0);
    load(1, 16'hE000, 1);
    check(underrun == 1'b0, "R8 flag cleared", underrun, 0);
    wait_req("R8 recovered req");
    dma_ack = 1'b1;
    strobe(16'hE000, "R8 new word");
    check(dma_req == 1'b0 && underrun == 1'b0, "R8 clean end", {dma_req, underrun}, 0);
    dma_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_stray_rd();
    t_underrun();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule